// File: doc/BRIEF.md
# Bridge Configuration Space Register File

This block holds the configuration registers of a PCI-to-PCI bridge or root port in flops. It covers the 64-byte Type 1 header and, when enabled by a parameter, a PCI Express capability structure that starts at byte 0x40 and runs to byte 0x73. Every bit in every dword has one attribute: read-only, read-write or write-one-to-clear. A bit with none of these is reserved. Reserved bits have no storage and always read as zero.

Software reaches the registers through a request port. Each request carries a byte address, a size of 1, 2 or 4 bytes, a write flag and write data. Each accepted request produces exactly one response, which carries read data and an error flag. Both sides use valid/ready:
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is high whenever no response is pending or the pending response is being taken in the same cycle.
- A response is held unchanged until `rsp_ready` is high.

Hardware reaches the registers through two sideband inputs:
- An event input sets write-one-to-clear status bits in one dword.
- A load input replaces the pure read-only fields of one dword, for example identity, link state or slot state.

Top module: `cfgsp_top`

## Requirements
- R1: A read returns 0 in every bit that has no read-only, read-write or write-one-to-clear attribute, whatever was written to that bit.
- R2: A read of size 4 ignores address bits 1:0 and returns the whole dword. A read of size 1 or 2 returns the dword shifted right by 8 × addr[1:0], masked to 8 or 16 bits, with the upper bits zero.
- R3: A request whose size is not 1, 2 or 4 returns `rsp_err` = 1 and read data 0, and it changes no register.
- R4: A write updates only read-write bits that lie inside the byte lanes it covers. The lane mask is 0xFF or 0xFFFF shifted left by 8 × addr[1:0], or all 32 bits for size 4. Read-only bits and bits outside the lanes keep their values.
- R5: A write clears each write-one-to-clear bit inside its lanes where the shifted write data is 1. Where the shifted write data is 0, the bit is left unchanged.
- R6: With the capability present, byte addresses at or above 0x74 read as 0 and ignore writes. Without it, the limit is 0x40. Such accesses are not errors.
- R7: After reset, the block holds these values:
  - dword 0x04 = 0x00100000 (capability-list status bit)
  - dword 0x08 = 0x06040000 (bridge class code)
  - dword 0x0C = 0x00010010 (header type 1, cache line 0x10)
  - dword 0x34 = 0x40 with the capability, 0 without it
  - dword 0x40 = 0x01420010 (capability ID 0x10, version 2, root port, slot implemented)
- R8: When parameter `NO_PREF_WIN` is set, dword 0x24 (prefetchable window) is read-only. Otherwise its bits 31:20 and 15:4 are read-write.
- R9: An event pulse sets the write-one-to-clear bits of the selected dword that are selected by `evt_bits`. If a software clear of the same bit happens in the same cycle, the event wins.
- R10: A load pulse replaces the pure read-only bits of the selected dword with `ld_data`. Read-write and write-one-to-clear bits are unchanged.
- R11: The response to an accepted request appears with `rsp_valid` at the next clock edge. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and the response stays stable.
- R12: A write response returns `rsp_err` = 0 and read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request may be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 3 | Access size in bytes (1, 2, 4 legal) |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data, right-aligned |
| rsp_err | output | 1 | Illegal size flag |
| evt_valid | input | 1 | Status event pulse |
| evt_index | input | ADDR_W-2 | Dword index for the event |
| evt_bits | input | 32 | Status bits to set |
| ld_valid | input | 1 | Read-only field load pulse |
| ld_index | input | ADDR_W-2 | Dword index for the load |
| ld_data | input | 32 | New read-only field values |

## Verification
The embedded assertions check the following on every cycle:
- Read-only bits do not change on a write.
- Written read-write lanes take the new data.
- A status event always leaves its bits set, even when a clear lands in the same cycle.
- A stalled response holds steady.
- Every accepted request produces a response.
- Illegal sizes are flagged.
- Byte reads carry no upper bits.

Other behaviours can only be shown by the bench scenarios, which are compared against a behavioural model of the register space:
- Reserved bits reading as zero.
- Reset contents.
- Lane shifting of narrow accesses.
- The address cut-off.
- The two parameter variants.

// File: rtl/cfgsp_pkg.sv
`timescale 1ns/1ps
package cfgsp_pkg;

  typedef struct packed {
    logic [31:0] ro;
    logic [31:0] rw;
    logic [31:0] w1c;
  } attr_t;

  localparam int HDR_DWORDS = 16;
  localparam int CAP_DWORDS = 13;

  function automatic attr_t attr_of(input int idx, input bit has_cap, input bit no_pref);
    attr_t a;
    a = '0;
    case (idx)
      0, 2, 3, 4, 5: a.ro = 32'hFFFF_FFFF;
      1: begin
        a.rw  = 32'h0000_0147;
        a.ro  = 32'h06B0_02B8;
        a.w1c = 32'hF900_0000;
      end
      6: begin
        a.rw = 32'h01FF_FFFF;
        a.ro = 32'hFF00_0000;
      end
      7: begin
        a.rw  = 32'h0000_F0F0;
        a.ro  = 32'h06B0_0F0F;
        a.w1c = 32'hF900_0000;
      end
      8: begin
        a.rw = 32'hFFF0_FFF0;
        a.ro = 32'h000F_000F;
      end
      9: begin
        if (no_pref) begin
          a.ro = 32'hFFFF_FFFF;
        end else begin
          a.rw = 32'hFFF0_FFF0;
          a.ro = 32'h000F_000F;
        end
      end
      10, 11, 12: a.rw = 32'hFFFF_FFFF;
      13: a.ro = 32'h0000_00FF;
      14: a.rw = 32'hFFFF_F801;
      15: begin
        a.rw  = 32'h0B6F_00FF;
        a.ro  = 32'h0080_FF00;
        a.w1c = 32'h0400_0000;
      end
      default: a = '0;
    endcase
    if (has_cap) begin
      case (idx)
        16, 17, 21: a.ro = 32'hFFFF_FFFF;
        18: begin
          a.rw  = 32'h0000_FFFF;
          a.ro  = 32'h0030_0000;
          a.w1c = 32'h004F_0000;
        end
        19: a.ro = 32'hFF7F_FFFF;
        20: begin
          a.rw  = 32'h0000_CFFB;
          a.ro  = 32'h3FFF_0000;
          a.w1c = 32'hC000_0000;
        end
        22: begin
          a.rw  = 32'h0000_7FFF;
          a.ro  = 32'h00E0_0000;
          a.w1c = 32'h011F_0000;
        end
        23: begin
          a.rw = 32'h0000_001F;
          a.ro = 32'h0001_0000;
        end
        24: begin
          a.ro  = 32'h0002_FFFF;
          a.w1c = 32'h0001_0000;
        end
        default: ;
      endcase
    end
    return a;
  endfunction

  function automatic logic [31:0] reset_of(input int idx, input bit has_cap);
    logic [31:0] v;
    case (idx)
      1:  v = 32'h0010_0000;
      2:  v = 32'h0604_0000;
      3:  v = 32'h0001_0010;
      13: v = has_cap ? 32'h0000_0040 : 32'h0;
      16: v = has_cap ? 32'h0142_0010 : 32'h0;
      default: v = 32'h0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cfgsp_lane.sv
`timescale 1ns/1ps
module cfgsp_lane #(
  parameter int ADDR_W   = 8,
  parameter int END_BYTE = 116,
  localparam int IDX_W   = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output logic [IDX_W-1:0]  idx,
  output logic [4:0]        shift,
  output logic [31:0]       lane,
  output logic [31:0]       rmask,
  output logic              size_ok,
  output logic              in_range
);
  always_comb begin
    idx      = addr[ADDR_W-1:2];
    in_range = (32'(addr) < 32'(END_BYTE));
    size_ok  = 1'b1;
    shift    = {addr[1:0], 3'b000};
    lane     = 32'hFFFF_FFFF;
    rmask    = 32'hFFFF_FFFF;
    case (size)
      3'd1: begin
        lane  = 32'h0000_00FF << shift;
        rmask = 32'h0000_00FF;
      end
      3'd2: begin
        lane  = 32'h0000_FFFF << shift;
        rmask = 32'h0000_FFFF;
      end
      3'd4: shift = 5'd0;
      default: begin
        size_ok = 1'b0;
        lane    = 32'h0;
        rmask   = 32'h0;
      end
    endcase
  end
endmodule

// File: rtl/cfgsp_dword.sv
`timescale 1ns/1ps
module cfgsp_dword #(
  parameter logic [31:0] RO  = 32'h0,
  parameter logic [31:0] RW  = 32'h0,
  parameter logic [31:0] W1C = 32'h0,
  parameter logic [31:0] RST = 32'h0,
  localparam logic [31:0] KEEP    = RO | RW | W1C,
  localparam logic [31:0] RO_ONLY = RO & ~RW & ~W1C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_lane,
  input  logic [31:0] wr_data,
  input  logic        evt_en,
  input  logic [31:0] evt_bits,
  input  logic        ld_en,
  input  logic [31:0] ld_data,
  output logic [31:0] q
);
  logic [31:0] nxt;

  always_comb begin
    nxt = q;
    if (ld_en)
      nxt = (nxt & ~RO_ONLY) | (ld_data & RO_ONLY);
    if (wr_en) begin
      nxt = (nxt & ~(wr_lane & RW)) | (wr_data & wr_lane & RW);
      nxt = nxt & ~(wr_data & wr_lane & W1C);
    end
    if (evt_en)
      nxt = nxt | (evt_bits & W1C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST & KEEP;
    else        q <= nxt & KEEP;
  end

  assert_ro_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ld_en) |=> ((q & RO_ONLY) == ($past(q) & RO_ONLY)));

  assert_rw_loaded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & RW & $past(wr_lane)) == ($past(wr_data) & RW & $past(wr_lane))));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_en && ((evt_bits & W1C) != 32'h0)) |=>
      ((q & $past(evt_bits) & W1C) == ($past(evt_bits) & W1C)));
endmodule

// File: rtl/cfgsp_top.sv
`timescale 1ns/1ps
module cfgsp_top #(
  parameter int ADDR_W      = 8,
  parameter bit HAS_CAP     = 1'b1,
  parameter bit NO_PREF_WIN = 1'b0,
  localparam int IDX_W      = ADDR_W - 2,
  localparam int NDW        = HAS_CAP ? (cfgsp_pkg::HDR_DWORDS + cfgsp_pkg::CAP_DWORDS)
                                      : cfgsp_pkg::HDR_DWORDS,
  localparam int END_BYTE   = NDW * 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic              evt_valid,
  input  logic [IDX_W-1:0]  evt_index,
  input  logic [31:0]       evt_bits,
  input  logic              ld_valid,
  input  logic [IDX_W-1:0]  ld_index,
  input  logic [31:0]       ld_data
);
  logic [IDX_W-1:0] idx;
  logic [4:0]       shift;
  logic [31:0]      lane, rmask, wdata_sh, rd_word, rd_aligned;
  logic             size_ok, in_range, accept, wr_go;
  logic [31:0]      dq [NDW];

  cfgsp_lane #(.ADDR_W(ADDR_W), .END_BYTE(END_BYTE)) u_lane (
    .addr(req_addr), .size(req_size), .idx(idx), .shift(shift),
    .lane(lane), .rmask(rmask), .size_ok(size_ok), .in_range(in_range)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_go     = accept && req_write && size_ok && in_range;
  assign wdata_sh  = req_wdata << shift;

  for (genvar g = 0; g < NDW; g++) begin : g_dw
    localparam cfgsp_pkg::attr_t A = cfgsp_pkg::attr_of(g, HAS_CAP, NO_PREF_WIN);
    localparam logic [31:0] R0 = cfgsp_pkg::reset_of(g, HAS_CAP);
    cfgsp_dword #(.RO(A.ro), .RW(A.rw), .W1C(A.w1c), .RST(R0)) u_dw (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_go && (idx == IDX_W'(g))),
      .wr_lane(lane), .wr_data(wdata_sh),
      .evt_en(evt_valid && (evt_index == IDX_W'(g))), .evt_bits(evt_bits),
      .ld_en(ld_valid && (ld_index == IDX_W'(g))), .ld_data(ld_data),
      .q(dq[g])
    );
  end

  always_comb begin
    rd_word = 32'h0;
    for (int i = 0; i < NDW; i++)
      if (in_range && (idx == IDX_W'(i))) rd_word = dq[i];
    rd_aligned = (rd_word >> shift) & rmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'h0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_err   <= !size_ok;
      rsp_rdata <= (!req_write && size_ok) ? rd_aligned : 32'h0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  assert_accept_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_bad_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_size != 3'd1) && (req_size != 3'd2) && (req_size != 3'd4))
      |=> (rsp_err && (rsp_rdata == 32'h0)));

  assert_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && (req_size == 3'd1)) |=> (rsp_rdata[31:8] == 24'h0));
endmodule

// File: tb/cfgsp_top_test.sv
`timescale 1ns/1ps
module cfgsp_top_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [7:0] req_addr = 0;
  logic [2:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic evt_valid = 0, ld_valid = 0;
  logic [5:0] evt_index = 0, ld_index = 0;
  logic [31:0] evt_bits = 0, ld_data = 0;
  logic req_ready, rsp_valid, rsp_err, a_req_ready, a_rsp_valid, a_rsp_err;
  logic [31:0] rsp_rdata, a_rsp_rdata;
  int checks = 0, fails = 0;
  logic [31:0] mem [64];
  logic [31:0] alt_last;

  always #10 clk = ~clk;

  cfgsp_top uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .evt_valid(evt_valid), .evt_index(evt_index), .evt_bits(evt_bits),
    .ld_valid(ld_valid), .ld_index(ld_index), .ld_data(ld_data));

  cfgsp_top #(.HAS_CAP(1'b0), .NO_PREF_WIN(1'b1)) uut_alt (.clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(a_req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .rsp_valid(a_rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(a_rsp_rdata), .rsp_err(a_rsp_err), .evt_valid(evt_valid), .evt_index(evt_index),
    .evt_bits(evt_bits), .ld_valid(ld_valid), .ld_index(ld_index), .ld_data(ld_data));

  // attribute model by byte offset (capability present, prefetch window enabled)
  function automatic logic [95:0] attrs(input int off); // {ro, rw, w1c}
    case (off)
      'h00, 'h08, 'h0C, 'h10, 'h14, 'h40, 'h44, 'h54: return {32'hFFFFFFFF, 64'h0};
      'h04: return {32'h06B002B8, 32'h00000147, 32'hF9000000};
      'h18: return {32'hFF000000, 32'h01FFFFFF, 32'h0};
      'h1C: return {32'h06B00F0F, 32'h0000F0F0, 32'hF9000000};
      'h20, 'h24: return {32'h000F000F, 32'hFFF0FFF0, 32'h0};
      'h28, 'h2C, 'h30: return {32'h0, 32'hFFFFFFFF, 32'h0};
      'h34: return {32'h000000FF, 64'h0};
      'h38: return {32'h0, 32'hFFFFF801, 32'h0};
      'h3C: return {32'h0080FF00, 32'h0B6F00FF, 32'h04000000};
      'h48: return {32'h00300000, 32'h0000FFFF, 32'h004F0000};
      'h4C: return {32'hFF7FFFFF, 64'h0};
      'h50: return {32'h3FFF0000, 32'h0000CFFB, 32'hC0000000};
      'h58: return {32'h00E00000, 32'h00007FFF, 32'h011F0000};
      'h5C: return {32'h00010000, 32'h0000001F, 32'h0};
      'h60: return {32'h0002FFFF, 32'h0, 32'h00010000};
      default: return 96'h0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic model_apply(input bit wr, input logic [7:0] a, input logic [2:0] sz,
                             input logic [31:0] d, output logic [31:0] ed, output bit ee);
    logic [95:0] t;
    int sh;
    logic [31:0] ln, v, un;
    ed = 0; ee = 0;
    if (sz != 1 && sz != 2 && sz != 4) begin ee = 1; return; end
    if (a >= 8'h74) return;
    t  = attrs(int'(a) & 'hFC);
    un = t[95:64] | t[63:32] | t[31:0];
    sh = (sz == 4) ? 0 : 8 * int'(a[1:0]);
    if (!wr) begin
      v  = (mem[a >> 2] & un) >> sh;
      ed = (sz == 1) ? (v & 32'hFF) : (sz == 2) ? (v & 32'hFFFF) : v;
    end else begin
      ln = (sz == 4) ? 32'hFFFFFFFF : (((sz == 1) ? 32'hFF : 32'hFFFF) << sh);
      v  = d << sh;
      mem[a >> 2] = (mem[a >> 2] & ~(ln & t[63:32])) | (v & ln & t[63:32]);
      mem[a >> 2] = mem[a >> 2] & ~(v & ln & t[31:0]);
    end
  endtask

  task automatic xfer(input bit wr, input logic [7:0] a, input logic [2:0] sz,
                      input logic [31:0] d, input string req);
    logic [31:0] ed; bit ee;
    model_apply(wr, a, sz, d, ed, ee);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    alt_last = a_rsp_rdata;
    chk(rsp_valid === 1'b1, {req, "/R11 valid"}, {31'h0, rsp_valid}, 32'h1);
    chk(rsp_err === ee, {req, " err"}, {31'h0, rsp_err}, {31'h0, ee});
    chk(rsp_rdata === ed, req, rsp_rdata, ed);
  endtask

  task automatic evt(input int i, input logic [31:0] b);
    @(negedge clk);
    evt_valid = 1; evt_index = 6'(i); evt_bits = b;
    mem[i] = mem[i] | (b & attrs(i * 4)[31:0]);
    @(negedge clk);
    evt_valid = 0;
  endtask

  task automatic load(input int i, input logic [31:0] d);
    logic [95:0] t; logic [31:0] ro_only;
    t = attrs(i * 4);
    ro_only = t[95:64] & ~t[63:32] & ~t[31:0];
    @(negedge clk);
    ld_valid = 1; ld_index = 6'(i); ld_data = d;
    mem[i] = (mem[i] & ~ro_only) | (d & ro_only);
    @(negedge clk);
    ld_valid = 0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] ed; bit ee; logic [31:0] held;
    for (int i = 0; i < 64; i++) mem[i] = 0;
    mem[1] = 32'h00100000; mem[2] = 32'h06040000; mem[3] = 32'h00010010;
    mem[13] = 32'h40; mem[16] = 32'h01420010;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R11 reset rsp_valid", {31'h0, rsp_valid}, 0);
    chk(req_ready === 1'b1, "R11 reset req_ready", {31'h0, req_ready}, 1);
    // R7 reset contents
    xfer(0, 8'h08, 4, 0, "R7 class");
    xfer(0, 8'h0C, 4, 0, "R7 header");
    xfer(0, 8'h04, 4, 0, "R7 status");
    xfer(0, 8'h34, 4, 0, "R7 cap pointer");
    xfer(0, 8'h40, 4, 0, "R7 cap header");
    // R10 identity load
    load(0, 32'hABCD1234);
    xfer(0, 8'h00, 4, 0, "R10 id load");
    load(1, 32'hFFFFFFFF);
    xfer(0, 8'h04, 4, 0, "R10 load leaves rw/w1c");
    // R4 R5 R1 full write
    xfer(1, 8'h04, 4, 32'hFFFFFFFF, "R12 write rsp");
    xfer(0, 8'h04, 4, 0, "R4 R1 command rw");
    // R9 event then R5 clear
    evt(1, 32'hFFFFFFFF);
    xfer(0, 8'h04, 4, 0, "R9 event set");
    xfer(1, 8'h06, 2, 32'h0800, "R5 w1c write");
    xfer(0, 8'h04, 4, 0, "R5 w1c cleared one bit");
    // R9 set wins over clear in the same cycle
    model_apply(1, 8'h07, 1, 32'h10, ed, ee);
    mem[1] = mem[1] | 32'h10000000;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'h07; req_size = 1; req_wdata = 32'h10;
    evt_valid = 1; evt_index = 6'd1; evt_bits = 32'h10000000;
    @(negedge clk);
    req_valid = 0; evt_valid = 0;
    xfer(0, 8'h04, 4, 0, "R9 set wins");
    // R2 narrow reads
    xfer(0, 8'h0E, 1, 0, "R2 byte read");
    xfer(0, 8'h0A, 2, 0, "R2 half read");
    xfer(0, 8'h0F, 1, 0, "R2 top byte");
    xfer(0, 8'h0E, 4, 0, "R2 size4 ignores low bits");
    // R4 narrow write merge
    xfer(1, 8'h19, 1, 32'h5A, "R12 byte write");
    xfer(1, 8'h1B, 1, 32'hEE, "R12 ro byte write");
    xfer(0, 8'h18, 4, 0, "R4 byte merge");
    xfer(1, 8'h1C, 4, 32'hFFFFFFFF, "R12 io write");
    xfer(0, 8'h1C, 4, 0, "R4 io nibble");
    // R3 bad sizes
    xfer(0, 8'h28, 3, 0, "R3 bad read");
    xfer(1, 8'h28, 0, 32'h12345678, "R3 bad write");
    xfer(0, 8'h28, 4, 0, "R3 no change");
    xfer(1, 8'h28, 4, 32'hCAFEF00D, "R12 window write");
    xfer(1, 8'h28, 7, 32'h0, "R3 bad write 7");
    xfer(0, 8'h28, 4, 0, "R3 still kept");
    // R6 range
    xfer(1, 8'h74, 4, 32'hFFFFFFFF, "R6 oor write");
    xfer(0, 8'h74, 4, 0, "R6 oor read");
    xfer(0, 8'hFC, 4, 0, "R6 far read");
    xfer(1, 8'h70, 4, 32'hFFFFFFFF, "R12 reserved write");
    xfer(0, 8'h70, 4, 0, "R1 reserved dword");
    // R1 reserved bits in capability
    xfer(1, 8'h58, 4, 32'hFFFFFFFF, "R12 slot write");
    xfer(0, 8'h58, 4, 0, "R1 R5 slot dword");
    xfer(1, 8'h60, 4, 32'hFFFFFFFF, "R12 root sts write");
    xfer(0, 8'h60, 4, 0, "R5 root status");
    // R8 prefetch window on both variants
    xfer(1, 8'h24, 4, 32'hFFFFFFFF, "R12 pref write");
    xfer(0, 8'h24, 4, 0, "R8 pref rw");
    chk(alt_last === 32'h0, "R8 no-pref read-only", alt_last, 0);
    xfer(0, 8'h40, 4, 0, "R7 cap header kept");
    chk(alt_last === 32'h0, "R6 alt cut-off 0x40", alt_last, 0);
    xfer(0, 8'h34, 4, 0, "R7 cap ptr");
    chk(alt_last === 32'h0, "R7 alt cap ptr zero", alt_last, 0);
    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 0;
    model_apply(0, 8'h0C, 4, 0, ed, ee);
    held = ed;
    req_valid = 1; req_write = 0; req_addr = 8'h0C; req_size = 4;
    @(negedge clk);
    req_addr = 8'h00;
    chk(req_ready === 1'b0, "R11 stall ready", {31'h0, req_ready}, 0);
    chk(rsp_rdata === held, "R11 stall data", rsp_rdata, held);
    @(negedge clk);
    chk(req_ready === 1'b0, "R11 stall ready 2", {31'h0, req_ready}, 0);
    chk(rsp_rdata === held && rsp_valid === 1'b1, "R11 held", rsp_rdata, held);
    rsp_ready = 1;
    model_apply(0, 8'h00, 4, 0, ed, ee);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1, "R11 next valid", {31'h0, rsp_valid}, 1);
    chk(rsp_rdata === ed, "R11 next data", rsp_rdata, ed);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R11 drained", {31'h0, rsp_valid}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule